// File: doc/BRIEF.md
# Fractional Microsecond Tick Counter

This block derives a one-microsecond time base from an oscillator whose frequency need not be a whole number of megahertz. A 16-bit ratio word sets the rate. Its high byte is a numerator step and its low byte is a denominator limit, and both are stored as value minus one. On every oscillator clock a phase accumulator adds the numerator. Each time the phase reaches the denominator, the denominator is taken off and a one-cycle tick is issued. Over any stretch of clocks that starts from a clean phase, the ticks therefore follow the exact rational rate (A+1)/(B+1) ticks per clock, with no long-term drift.

Each tick also advances a free-running up-counter, which wraps and can be read over a small register bus. Software can rewrite the ratio word at any time, for example to restore it after a power-state change. Such a write also restarts the phase. A hold bit freezes both the phase and the counter. The register bus is plain control access: a write strobe, a read strobe, an address and data. It has no back-pressure. Writes take effect on the clock edge where the strobe is high, and read data is registered and valid one cycle after the read strobe. The tick output drives other timers directly.

Top module: `usec_tick_gen`

## Requirements
- R1: After reset the ratio word reads 0x000B, the counter reads 0, the hold bit reads 0 and `usec_tick` is low.
- R2: Address 0 holds the ratio word. Bits 15:8 are field A and bits 7:0 are field B. A write stores the low 16 bits of the write data, and a read returns them with bits 31:16 zero.
- R3: When A <= B, exactly floor(n*(A+1)/(B+1)) ticks appear in the first n clocks after a ratio write, with each tick lasting one clock.
- R4: When A > B (an illegal setting), `usec_tick` is high on every clock after the ratio write.
- R5: A ratio write clears the phase. `usec_tick` is low in the cycle after the write, and with ratio 0x000B the first tick comes exactly 12 clocks after the write, whatever the phase was before.
- R6: Address 1 reads the counter. It advances by exactly one for each clock in which `usec_tick` is high.
- R7: The counter wraps modulo 2^CNT_W.
- R8: Bit 0 of address 2 is the hold bit, and it reads back. While it is set, no tick is produced and the counter holds its value.
- R9: Writes to address 1 and address 3 have no effect. The counter value is unchanged by them.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_rd` is high. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address (0 ratio, 1 counter, 2 hold, 3 reserved) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| usec_tick | output | 1 | One-clock microsecond tick |

## Verification
A wrong phase value shows at the ports as a tick that comes early or late. For a ratio with a large denominator this can take up to B+1 clocks to appear, so tick counts are compared over windows of several periods, with each window starting at a ratio write. A counter that misses or repeats a step shows up as a mismatch the next time the counter is read while held, and that read is compared with the bench's own tally of observed ticks. A narrow-counter second instance brings out wrap errors within a few dozen ticks.

// File: rtl/utick_pkg.sv
package utick_pkg;
  typedef enum logic [1:0] {
    ADDR_RATIO = 2'd0,
    ADDR_COUNT = 2'd1,
    ADDR_HOLD  = 2'd2,
    ADDR_RSVD  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/utick_regs.sv
module utick_regs
  import utick_pkg::*;
#(
  parameter int RATIO_W = 8,
  parameter int CNT_W = 32,
  parameter int DATA_W = 32,
  parameter logic [2*RATIO_W-1:0] RESET_CFG = 16'h000B
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [1:0]          addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [CNT_W-1:0]    count,
  output logic [RATIO_W-1:0]  cfg_a,
  output logic [RATIO_W-1:0]  cfg_b,
  output logic                hold,
  output logic                cfg_load,
  output logic [DATA_W-1:0]   rdata
);
  localparam int CFG_W = 2 * RATIO_W;

  logic [CFG_W-1:0]  cfg_q;
  logic              hold_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  reg_addr_e         sel;

  assign sel      = reg_addr_e'(addr);
  assign cfg_load = wr_en && (sel == ADDR_RATIO);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= RESET_CFG;
      hold_q <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        ADDR_RATIO: cfg_q  <= wdata[CFG_W-1:0];
        ADDR_HOLD:  hold_q <= wdata[0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      ADDR_RATIO: rd_mux = DATA_W'(cfg_q);
      ADDR_COUNT: rd_mux = DATA_W'(count);
      ADDR_HOLD:  rd_mux = DATA_W'(hold_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign cfg_a = cfg_q[CFG_W-1:RATIO_W];
  assign cfg_b = cfg_q[RATIO_W-1:0];
  assign hold  = hold_q;
  assign rdata = rdata_q;

  a_r2_cfg_write_lands: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> ({cfg_a, cfg_b} == $past(wdata[CFG_W-1:0])));
endmodule

// File: rtl/utick_phase.sv
module utick_phase #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] cfg_a,
  input  logic [RATIO_W-1:0] cfg_b,
  input  logic               hold,
  input  logic               cfg_load,
  output logic               step,
  output logic               tick
);
  localparam int ACC_W = RATIO_W + 2;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] a_inc, b_lim, sum;
  logic             over, reach, tick_q;

  assign a_inc = ACC_W'(cfg_a) + ACC_W'(1);
  assign b_lim = ACC_W'(cfg_b) + ACC_W'(1);
  assign sum   = acc_q + a_inc;
  assign over  = a_inc > b_lim;
  assign reach = sum >= b_lim;
  assign step  = !hold && !cfg_load && (over || reach);

  always_comb begin
    if (cfg_load)   acc_d = '0;
    else if (hold)  acc_d = acc_q;
    else if (over)  acc_d = '0;
    else if (reach) acc_d = sum - b_lim;
    else            acc_d = sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= step;
    end
  end

  assign tick = tick_q;

  a_r5_no_tick_after_load: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> !tick);
  a_r8_no_tick_when_held: assert property (@(posedge clk) disable iff (rst)
    hold |=> !tick);
  a_r3_phase_below_limit: assert property (@(posedge clk) disable iff (rst)
    acc_q < b_lim);
  a_r4_illegal_every_clock: assert property (@(posedge clk) disable iff (rst)
    (over && !hold && !cfg_load) |=> tick);
endmodule

// File: rtl/utick_counter.sv
module utick_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             hold,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count = cnt_q;

  a_r6_step_advances: assert property (@(posedge clk) disable iff (rst)
    step |=> (count == $past(count) + CNT_W'(1)));
  a_r8_hold_keeps_count: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(count));
endmodule

// File: rtl/usec_tick_gen.sv
module usec_tick_gen #(
  parameter int RATIO_W = 8,
  parameter int CNT_W = 32,
  parameter int DATA_W = 32,
  parameter logic [2*RATIO_W-1:0] RESET_CFG = 16'h000B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              usec_tick
);
  logic [RATIO_W-1:0] cfg_a, cfg_b;
  logic               hold, cfg_load, step;
  logic [CNT_W-1:0]   count;

  utick_regs #(
    .RATIO_W(RATIO_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .RESET_CFG(RESET_CFG)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .count(count), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .hold(hold), .cfg_load(cfg_load), .rdata(bus_rdata)
  );

  utick_phase #(.RATIO_W(RATIO_W)) u_phase (
    .clk(clk), .rst(rst), .cfg_a(cfg_a), .cfg_b(cfg_b), .hold(hold),
    .cfg_load(cfg_load), .step(step), .tick(usec_tick)
  );

  utick_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .step(step), .hold(hold), .count(count)
  );

  a_r1_tick_low_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> !usec_tick);
endmodule

// File: tb/sim_usec_tick_gen.sv
`timescale 1ns/1ps
module sim_usec_tick_gen;
  localparam int DATA_W = 32;
  localparam int NVEC = 8;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h000B, 16'd120}, {16'h045F, 16'd192}, {16'h0453, 16'd200},
    {16'h000C, 16'd50},  {16'h0000, 16'd20},  {16'h0500, 16'd10},
    {16'h043F, 16'd130}, {16'h0219, 16'd77}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] rdata0, rdata1;
  logic tick0, tick1;
  int checks = 0, errors = 0;
  int seen = 0;

  always #2.5 clk = ~clk;

  usec_tick_gen u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
    .usec_tick(tick0)
  );

  usec_tick_gen #(.CNT_W(4)) u1 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
    .usec_tick(tick1)
  );

  always @(negedge clk) if (!rst && tick0) seen++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d0, output logic [31:0] d1);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d0 = rdata0; d1 = rdata1;
  endtask

  function automatic int expect_ticks(input logic [15:0] cfg, input int n);
    int an = int'(cfg[15:8]) + 1;
    int bn = int'(cfg[7:0]) + 1;
    if (an > bn) return n;
    return (n * an) / bn;
  endfunction

  task automatic run_tests();
    logic [31:0] r0, r1, held;
    int ticks, first;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 tick", {31'd0, tick0}, 32'd0);
    bus_read(2'd0, r0, r1); check("R1 ratio", r0, 32'h0000_000B);
    bus_read(2'd1, r0, r1); check("R1 counter", r0, seen);
    bus_read(2'd2, r0, r1); check("R1 hold", r0, 32'd0);
    // R2 ratio field readback
    bus_write(2'd0, 32'hABCD_5678);
    bus_read(2'd0, r0, r1); check("R2 readback", r0, 32'h0000_5678);
    // R3/R4/R6/R7 vector table
    for (int i = 0; i < NVEC; i++) begin
      bus_write(2'd0, {16'd0, VEC[i][31:16]});
      ticks = 0;
      for (int k = 0; k < int'(VEC[i][15:0]); k++) begin
        @(negedge clk);
        if (tick0) ticks++;
      end
      check((VEC[i][31:24] > VEC[i][23:16]) ? "R4 every clock" : "R3 tick count",
            ticks, expect_ticks(VEC[i][31:16], int'(VEC[i][15:0])));
      bus_write(2'd2, 32'd1);
      bus_read(2'd1, r0, r1);
      check("R6 counter", r0, seen);
      check("R7 wrap", r1, {28'd0, 4'(seen)});
      bus_write(2'd2, 32'd0);
    end
    // R5 phase restart
    bus_write(2'd0, 32'h000B);
    repeat (5) @(negedge clk);
    bus_write(2'd0, 32'h000B);
    check("R5 no tick after write", {31'd0, tick0}, 32'd0);
    first = 1;
    while (!tick0 && first < 40) begin
      @(negedge clk);
      if (!tick0) first++;
    end
    check("R5 first tick", first, 12);
    // R8 hold
    bus_write(2'd2, 32'd1);
    bus_read(2'd2, r0, r1); check("R8 hold readback", r0, 32'd1);
    bus_read(2'd1, held, r1);
    ticks = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (tick0) ticks++;
    end
    check("R8 no tick while held", ticks, 0);
    bus_read(2'd1, r0, r1); check("R8 counter held", r0, held);
    // R9 ignored writes
    bus_write(2'd1, 32'hDEAD_BEEF);
    bus_write(2'd3, 32'h1234_5678);
    bus_read(2'd1, r0, r1); check("R9 counter unchanged", r0, held);
    // R10 reserved address
    bus_read(2'd3, r0, r1); check("R10 reserved reads zero", r0, 32'd0);
    bus_write(2'd2, 32'd0);
    repeat (30) @(negedge clk);
    bus_write(2'd2, 32'd1);
    bus_read(2'd1, r0, r1); check("R6 counter after resume", r0, seen);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule